// File: doc/BRIEF.md
# Serial 4B/5B Receive Aligner

This block sits after clock recovery and descrambling on a 100 Mb/s receive path. It accepts one NRZ code bit per clock, with no knowledge of where 5-bit code groups begin. It watches the idle line (all ones) for carrier. It locks group alignment only on the two-group start-of-stream delimiter. From then on it turns each 5-bit code group into a 4-bit nibble on a nibble-wide receive interface, which carries data, data-valid, error and carrier-sense.

A carrier event that does not begin with the correct delimiter is treated as a false carrier. The error output then stays high and every group slot presents the fixed nibble 1110. This lasts until the line has returned to idle for two whole groups. A frame ends on the terminate pair. It is also cut short by two consecutive idle groups inside the frame. Invalid groups inside a frame are flagged one nibble at a time.

Top module: `symalign_rx`

## Requirements
- R1: A synchronous active-high reset clears crs, rx_dv, rx_er, nib_stb and rxd to zero and returns the block to unaligned idle hunting, with its bit history treated as all ones.
- R2: Bits are taken first-transmitted first, and a group written as b4..b0 has b4 received first. When the newly received bit is 0 and another 0 lies at least two positions earlier within the last ten bits, crs rises one clock after the edge that samples that bit. A 11000 group received after idle raises crs one clock after its fifth bit.
- R3: The five bits after carrier detection complete a ten-bit window. When that window equals 11000 followed by 10001, rx_dv rises one clock after the last bit, no nibble strobe is given in that cycle, and crs stays high.
- R4: After lock, every group that is a data code produces one nib_stb pulse with rx_er low and rx_dv high, one clock after the group's fifth bit. The codes are: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R5: After lock, groups are taken on the fixed boundary, so strobes inside a frame come exactly five clocks apart.
- R6: Group 01101 inside a frame drops rx_dv one clock after its last bit with no strobe. When the next group is 00111, crs drops one clock after that group's last bit with no strobe.
- R7: A group inside a frame that is neither a data code, 01101, nor the second of two idles gives a strobe with rx_er high, rxd 0000 and rx_dv high. A single idle group (11111) counts as such a group, and the frame continues.
- R8: When the ten-bit window after carrier detection is not the delimiter pair, rx_er goes high and stays high. rxd holds 1110, rx_dv stays low, and every later group slot on the boundary set by the detection gives a strobe.
- R9: During a false carrier, the second of two consecutive idle groups drops rx_er and crs one clock after its last bit, with no strobe for that group.
- R10: Two consecutive idle groups inside a frame drop rx_dv and crs one clock after the second one's last bit.
- R11: When the group after 01101 is not 00111, it gives one strobe with rx_er high, rxd 1110 and rx_dv low, and crs drops in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Descrambled NRZ code bit, one per clock |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |
| nib_stb | output | 1 | One-cycle pulse marking a new nibble slot |

## Verification
The bench streams whole code groups, one bit per clock, and records the clock-edge number at which each group's last bit is sampled. Every result of this block (carrier rise, lock, each strobe, each drop of data-valid, error or carrier) is due exactly one edge after the sampling edge of the bit that decides it. A monitor sampling at the falling clock edge logs the edge number of every output change and strobe. The checks then compare these logged numbers against the expected sampling edge plus one.

The one exception is a false carrier with arbitrary alignment. There the bench derives the boundaries from the bit that raised carrier: five bits later for the first error slot, then every five bits.

// File: rtl/symalign_pkg.sv
package symalign_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * SYM_W;
  localparam int CNT_W = $clog2(SYM_W);

  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_SSD1 = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_SSD2 = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_END1 = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_END2 = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_FALSE = 4'b1110;
  localparam logic [NIB_W-1:0] NIB_BAD   = 4'b0000;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SSD,
    ST_FRAME,
    ST_TAIL,
    ST_FALSE
  } align_st_t;

  typedef struct packed {
    logic             ok;
    logic [NIB_W-1:0] nib;
  } dec_t;

  function automatic dec_t dec_4b5b(input logic [SYM_W-1:0] c);
    dec_t d;
    d.ok = 1'b1;
    case (c)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      default: begin
        d.ok  = 1'b0;
        d.nib = NIB_BAD;
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/symalign_window.sv
module symalign_window #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [WIDTH-1:0] win
);
  always_ff @(posedge clk) begin
    if (rst) win <= '1;
    else     win <= {win[WIDTH-2:0], bit_in};
  end
endmodule

// File: rtl/symalign_cdet.sv
module symalign_cdet #(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] win,
  output logic             det
);
  localparam int GAP = 2;
  logic [WIDTH-GAP-1:0] far_zero;

  generate
    for (genvar i = GAP; i < WIDTH; i++) begin : g_far
      assign far_zero[i-GAP] = ~win[i];
    end
  endgenerate

  assign det = ~win[0] & (|far_zero);
endmodule

// File: rtl/symalign_decode.sv
module symalign_decode
  import symalign_pkg::*;
(
  input  logic [SYM_W-1:0] grp,
  output logic             ok,
  output logic [NIB_W-1:0] nib
);
  dec_t d;
  always_comb begin
    d   = dec_4b5b(grp);
    ok  = d.ok;
    nib = d.nib;
  end
endmodule

// File: rtl/symalign_rx.sv
module symalign_rx
  import symalign_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             crs,
  output logic             nib_stb
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_W - 1);
  localparam logic [WIN_W-1:0] SSD_PAIR = {SYM_SSD1, SYM_SSD2};

  logic [WIN_W-1:0] win;
  logic             det;
  logic             dec_ok;
  logic [NIB_W-1:0] dec_nib;
  logic [SYM_W-1:0] grp;
  logic             grp_done;
  logic             grp_idle;

  align_st_t        st;
  logic [CNT_W-1:0] cnt;
  logic             idle_seen;

  symalign_window #(.WIDTH(WIN_W)) u_win (
    .clk    (clk),
    .rst    (rst),
    .bit_in (rx_bit),
    .win    (win)
  );

  symalign_cdet #(.WIDTH(WIN_W)) u_cdet (
    .win (win),
    .det (det)
  );

  assign grp      = win[SYM_W-1:0];
  assign grp_done = (cnt == CNT_LAST);
  assign grp_idle = (grp == SYM_IDLE);

  symalign_decode u_dec (
    .grp (grp),
    .ok  (dec_ok),
    .nib (dec_nib)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_HUNT;
      cnt       <= '0;
      idle_seen <= 1'b0;
      rxd       <= '0;
      rx_dv     <= 1'b0;
      rx_er     <= 1'b0;
      crs       <= 1'b0;
      nib_stb   <= 1'b0;
    end else begin
      nib_stb <= 1'b0;
      rx_er   <= (st == ST_FALSE);
      if (st != ST_HUNT) cnt <= grp_done ? '0 : cnt + 1'b1;
      case (st)
        ST_HUNT: begin
          if (det) begin
            st  <= ST_SSD;
            cnt <= '0;
            crs <= 1'b1;
          end
        end
        ST_SSD: begin
          if (grp_done) begin
            idle_seen <= 1'b0;
            if (win == SSD_PAIR) begin
              st    <= ST_FRAME;
              rx_dv <= 1'b1;
            end else begin
              st      <= ST_FALSE;
              rx_er   <= 1'b1;
              rxd     <= NIB_FALSE;
              nib_stb <= 1'b1;
            end
          end
        end
        ST_FRAME: begin
          if (grp_done) begin
            if (dec_ok) begin
              rxd       <= dec_nib;
              nib_stb   <= 1'b1;
              idle_seen <= 1'b0;
            end else if (grp == SYM_END1) begin
              st    <= ST_TAIL;
              rx_dv <= 1'b0;
            end else if (grp_idle && idle_seen) begin
              st    <= ST_HUNT;
              rx_dv <= 1'b0;
              crs   <= 1'b0;
            end else begin
              rxd       <= NIB_BAD;
              rx_er     <= 1'b1;
              nib_stb   <= 1'b1;
              idle_seen <= grp_idle;
            end
          end
        end
        ST_TAIL: begin
          if (grp_done) begin
            st  <= ST_HUNT;
            crs <= 1'b0;
            if (grp != SYM_END2) begin
              rxd     <= NIB_FALSE;
              rx_er   <= 1'b1;
              nib_stb <= 1'b1;
            end
          end
        end
        ST_FALSE: begin
          if (grp_done) begin
            if (grp_idle && idle_seen) begin
              st    <= ST_HUNT;
              rx_er <= 1'b0;
              crs   <= 1'b0;
            end else begin
              idle_seen <= grp_idle;
              rxd       <= NIB_FALSE;
              nib_stb   <= 1'b1;
            end
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

  AST_DV_NEEDS_CRS: assert property (@(posedge clk) disable iff (rst)
    rx_dv |-> crs); // R3
  AST_LOCK_NO_STB: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_dv) |-> !nib_stb); // R3
  AST_STB_SPACED: assert property (@(posedge clk) disable iff (rst)
    nib_stb |=> !nib_stb); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LAST); // R5
  AST_DV_DROP_NO_STB: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dv) |-> !nib_stb); // R6
  AST_FALSE_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (rx_er && !rx_dv) |-> (rxd == NIB_FALSE)); // R8
  AST_ER_CLEAR_AT_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(crs) && !nib_stb |-> !rx_er); // R9
endmodule

// File: tb/symalign_rx_test.sv
`timescale 1ns/1ps
module symalign_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, crs, nib_stb;

  symalign_rx uut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs), .nib_stb(nib_stb)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int last_t;

  int crs_rise = -1, crs_fall = -1, dv_rise = -1, dv_fall = -1, er_fall = -1;
  logic p_crs = 0, p_dv = 0, p_er = 0;
  int nlog = 0;
  int s_cyc [0:255];
  logic [3:0] s_nib [0:255];
  logic s_er [0:255];
  logic s_dv [0:255];

  always @(negedge clk) begin
    if (rst) begin
      p_crs = 0; p_dv = 0; p_er = 0;
    end else begin
      if (crs && !p_crs) crs_rise = cyc;
      if (!crs && p_crs) crs_fall = cyc;
      if (rx_dv && !p_dv) dv_rise = cyc;
      if (!rx_dv && p_dv) dv_fall = cyc;
      if (!rx_er && p_er) er_fall = cyc;
      if (nib_stb && nlog < 256) begin
        s_cyc[nlog] = cyc; s_nib[nlog] = rxd;
        s_er[nlog] = rx_er; s_dv[nlog] = rx_dv;
        nlog++;
      end
      p_crs = crs; p_dv = rx_dv; p_er = rx_er;
    end
  end

  function automatic logic [4:0] enc(input int d);
    case (d)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
      12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  localparam logic [4:0] GI = 5'b11111, GJ = 5'b11000, GK = 5'b10001,
                         GT = 5'b01101, GR = 5'b00111;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk); rx_bit = g[i];
      @(posedge clk);
    end
    #1 last_t = cyc;
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) send(GI);
  endtask

  task automatic chk_stb(input string req, input int idx, input int t,
                         input int nib, input int er, input int dv);
    if (idx >= nlog) begin
      chk({req, " strobe present"}, 0, 1);
    end else begin
      chk({req, " strobe cycle"}, s_cyc[idx], t + 1);
      chk({req, " nibble/er/dv"}, {s_er[idx], s_dv[idx], s_nib[idx]},
          {er[0], dv[0], nib[3:0]});
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n0, tj, tk, tt, tr, ta, t1, t2, t3, t4;
    int td [0:15];
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {crs, rx_dv, rx_er, nib_stb, rxd}, 0);
    rst = 0;

    // idle only: no carrier
    idles(4);
    @(negedge clk);
    chk("R2 idle keeps crs low", crs, 0);
    chk("R2 idle no strobe", nlog, 0);

    // good frame, all sixteen data codes
    n0 = nlog;
    send(GJ); tj = last_t;
    send(GK); tk = last_t;
    for (int d = 0; d < 16; d++) begin send(enc(d)); td[d] = last_t; end
    send(GT); tt = last_t;
    send(GR); tr = last_t;
    idles(3);
    chk("R2 crs rise after J", crs_rise, tj + 1);
    chk("R3 dv rise after K", dv_rise, tk + 1);
    chk("R4 strobe count", nlog - n0, 16);
    for (int d = 0; d < 16; d++) chk_stb("R4", n0 + d, td[d], d, 0, 1);
    for (int d = 1; d < 16; d++)
      chk("R5 strobe spacing", s_cyc[n0 + d] - s_cyc[n0 + d - 1], 5);
    chk("R6 dv fall after T", dv_fall, tt + 1);
    chk("R6 crs fall after R", crs_fall, tr + 1);

    // invalid groups and a single idle inside a frame
    n0 = nlog;
    send(GJ); send(GK);
    send(enc(5)); t1 = last_t;
    send(5'b00000); t2 = last_t;
    send(enc(10));
    send(5'b00100); t3 = last_t;
    send(GI); t4 = last_t;
    send(enc(7)); ta = last_t;
    send(GT); send(GR); idles(3);
    chk("R7 strobe count", nlog - n0, 6);
    chk_stb("R7 data", n0, t1, 5, 0, 1);
    chk_stb("R7 invalid 00000", n0 + 1, t2, 0, 1, 1);
    chk_stb("R7 invalid 00100", n0 + 3, t3, 0, 1, 1);
    chk_stb("R7 single idle", n0 + 4, t4, 0, 1, 1);
    chk_stb("R7 frame continues", n0 + 5, ta, 7, 0, 1);

    // false carrier on J-aligned bad delimiter
    n0 = nlog; tk = dv_rise;
    send(GJ); tj = last_t;
    send(enc(3)); t1 = last_t;
    send(enc(4)); t2 = last_t;
    send(GI); t3 = last_t;
    chk("R8 error held between slots", rx_er, 1);
    send(GI); t4 = last_t;
    idles(2);
    chk("R2 crs rise at bad J", crs_rise, tj + 1);
    chk("R8 dv never rises", dv_rise, tk);
    chk("R8 strobe count", nlog - n0, 3);
    chk_stb("R8 bad delimiter", n0, t1, 14, 1, 0);
    chk_stb("R8 false slot", n0 + 1, t2, 14, 1, 0);
    chk_stb("R8 first idle", n0 + 2, t3, 14, 1, 0);
    chk("R9 er fall", er_fall, t4 + 1);
    chk("R9 crs fall", crs_fall, t4 + 1);

    // false carrier at arbitrary alignment (zeros at bits 2 and 4)
    n0 = nlog;
    send(5'b10101); ta = last_t;
    idles(6);
    chk("R2 crs rise misaligned", crs_rise, ta);
    chk("R8 misaligned strobe count", nlog - n0, 2);
    chk_stb("R8 misaligned slot", n0, ta + 4, 14, 1, 0);
    chk_stb("R9 misaligned idle", n0 + 1, ta + 9, 14, 1, 0);
    chk("R9 misaligned crs fall", crs_fall, ta + 15);

    // premature end by two idles
    n0 = nlog;
    send(GJ); send(GK);
    send(enc(3)); t1 = last_t;
    send(GI); t2 = last_t;
    send(GI); t3 = last_t;
    idles(2);
    chk("R10 strobe count", nlog - n0, 2);
    chk_stb("R10 data", n0, t1, 3, 0, 1);
    chk_stb("R10 first idle error", n0 + 1, t2, 0, 1, 1);
    chk("R10 dv fall", dv_fall, t3 + 1);
    chk("R10 crs fall", crs_fall, t3 + 1);

    // T followed by a non-R group
    n0 = nlog;
    send(GJ); send(GK); send(enc(9));
    send(GT); tt = last_t;
    send(enc(0)); t1 = last_t;
    idles(3);
    chk("R11 dv fall at T", dv_fall, tt + 1);
    chk("R11 strobe count", nlog - n0, 2);
    chk_stb("R11 bad tail", n0 + 1, t1, 14, 1, 0);
    chk("R11 crs fall", crs_fall, t1 + 1);

    // reset in mid-frame, then recovery
    send(GJ); send(GK); send(enc(1)); send(enc(2));
    @(negedge clk); rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset mid-frame", {crs, rx_dv, rx_er, nib_stb, rxd}, 0);
    rst = 0;
    n0 = nlog;
    idles(2);
    send(GJ); tj = last_t;
    send(GK); send(enc(6)); t1 = last_t;
    send(GT); send(GR); idles(3);
    chk("R1 relock crs", crs_rise, tj + 1);
    chk("R1 relock strobe count", nlog - n0, 1);
    chk_stb("R1 relock data", n0, t1, 6, 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule